// File: doc/BRIEF.md
# Multiprocessor Interprocessor-Interrupt and Timer Register

This block holds one 64-bit control/status word that a small multiprocessor uses to signal between its CPUs and to deliver a periodic timer interrupt to every CPU. Any CPU may access the word over a simple register port. Each access carries the requester's CPU number. The block drives one interprocessor-interrupt (IPI) line and one timer line per CPU, and each line follows the pending bit stored for it.

A write can do three things in one cycle. Bits 15:12 post IPIs. Bits 11:8 clear pending IPIs. Bits 7:4 acknowledge timer interrupts. A timer tick input sets the timer pending bit of every CPU. A read returns the stored pending bits with the requester's CPU number merged into the two lowest bits. Only full-width accesses are legal. Any narrower access, and any write that touches no recognised field, is reported on a one-cycle error pulse.

Top module: `mptr_ipi_timer`

## Requirements
- R1: After a synchronous reset, every IPI line, every timer line, `err`, `rd_valid` and `rd_data` are zero.
- R2: A full-width write with bit 12+n set sets the IPI pending bit of CPU n and raises `ipi_irq[n]` on the next cycle. If that bit is already pending, it stays set.
- R3: A full-width write with bit 8+n set clears CPU n's IPI pending bit and drops `ipi_irq[n]` on the next cycle. If nothing is pending for CPU n, nothing changes.
- R4: A cycle with `tick` high sets the timer pending bit of every CPU, and all `tmr_irq` lines are high on the next cycle.
- R5: A full-width write with bit 4+n set clears CPU n's timer pending bit and drops `tmr_irq[n]`. If `tick` is high in the same cycle, the tick wins and the bit stays set.
- R6: A full-width read sets `rd_valid` and `rd_data` on the next cycle only. In `rd_data`, bits 7:4 hold the timer pending bits, bits 11:8 hold the IPI pending bits, bits 1:0 hold the requester's CPU number, and every other bit is zero.
- R7: A full-width write whose only set recognised bit is bit 28 raises no error and changes no state.
- R8: A full-width write with none of bits 15:4 and not bit 28 set pulses `err` high for exactly one cycle and changes no state.
- R9: An access with `acc_size` other than 3 (0 = byte, 1 = half, 2 = word, 3 = 64-bit) pulses `err` for one cycle. Such an access changes no state and returns no read data.
- R10: When one write both posts and clears the IPI of the same CPU, the post is applied first and the clear second, so the IPI ends cleared.
- R11: Without a write, the IPI lines hold their values. Without a write and without a tick, the timer lines hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access size code, 3 = full 64-bit |
| acc_cpu | input | 2 | Number of the requesting CPU |
| acc_wdata | input | 64 | Write data |
| tick | input | 1 | Timer event, one cycle per event |
| rd_data | output | 64 | Registered read data |
| rd_valid | output | 1 | rd_data holds a read result |
| err | output | 1 | One-cycle unsupported-access pulse |
| ipi_irq | output | NCPU | Per-CPU IPI line |
| tmr_irq | output | NCPU | Per-CPU timer line |

## Verification
A behavioural reference model runs in step with the design and is compared against it on every clock. The stimulus posts IPIs to one CPU and to several CPUs at once, posts to a CPU that is already pending, clears pending and idle CPUs, and mixes a post and a clear for the same CPU in one word. Together these cases separate a correct post-then-clear ordering from a reversed one and from plain overwriting. The timer cases pair an acknowledge with a tick and without one, which shows which of the two has priority. Reads issued from different CPU numbers, bit-28-only writes, empty writes, and narrow reads and writes check the field placement, the CPU-number merge and the error rules.

// File: rtl/mptr_pkg.sv
package mptr_pkg;
  localparam int REG_W    = 64;
  localparam int FIELD_W  = 4;
  localparam int CPU_ID_W = 2;
  localparam int TMR_LSB  = 4;
  localparam int IPI_LSB  = 8;
  localparam int POST_LSB = 12;
  localparam int ACK_BIT  = 28;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic               wr_ok;
    logic               rd_ok;
    logic               bad;
    logic [FIELD_W-1:0] post;
    logic [FIELD_W-1:0] ipi_clr;
    logic [FIELD_W-1:0] tmr_clr;
  } acc_dec_t;
endpackage

// File: rtl/mptr_decode.sv
module mptr_decode
  import mptr_pkg::*;
(
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       acc_size,
  input  logic [REG_W-1:0] acc_wdata,
  output acc_dec_t         dec
);
  logic full;
  logic recog;
  logic unused_bits;

  assign unused_bits = ^{acc_wdata[REG_W-1:ACK_BIT+1], acc_wdata[ACK_BIT-1:POST_LSB+FIELD_W],
                         acc_wdata[TMR_LSB-1:0]};

  always_comb begin
    full  = (acc_size == SZ_DWORD);
    recog = (|acc_wdata[POST_LSB +: FIELD_W]) | (|acc_wdata[IPI_LSB +: FIELD_W]) |
            (|acc_wdata[TMR_LSB +: FIELD_W]) | acc_wdata[ACK_BIT];
    dec.wr_ok   = acc_valid && acc_write && full;
    dec.rd_ok   = acc_valid && !acc_write && full;
    dec.bad     = acc_valid && (!full || (acc_write && !recog));
    dec.post    = dec.wr_ok ? acc_wdata[POST_LSB +: FIELD_W] : '0;
    dec.ipi_clr = dec.wr_ok ? acc_wdata[IPI_LSB +: FIELD_W]  : '0;
    dec.tmr_clr = dec.wr_ok ? acc_wdata[TMR_LSB +: FIELD_W]  : '0;
  end
endmodule

// File: rtl/mptr_ipi_bank.sv
module mptr_ipi_bank #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCPU-1:0] post,
  input  logic [NCPU-1:0] clr,
  output logic [NCPU-1:0] pend_q
);
  for (genvar n = 0; n < NCPU; n++) begin : g_cpu
    // post is applied first, clear second: clear wins on overlap
    always_ff @(posedge clk) begin
      if (rst)           pend_q[n] <= 1'b0;
      else if (clr[n])   pend_q[n] <= 1'b0;
      else if (post[n])  pend_q[n] <= 1'b1;
    end
  end
endmodule

// File: rtl/mptr_tmr_bank.sv
module mptr_tmr_bank #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [NCPU-1:0] ack,
  output logic [NCPU-1:0] pend_q
);
  for (genvar n = 0; n < NCPU; n++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst)          pend_q[n] <= 1'b0;
      else if (tick)    pend_q[n] <= 1'b1;
      else if (ack[n])  pend_q[n] <= 1'b0;
    end
  end
endmodule

// File: rtl/mptr_ipi_timer.sv
module mptr_ipi_timer
  import mptr_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [1:0]          acc_size,
  input  logic [CPU_ID_W-1:0] acc_cpu,
  input  logic [REG_W-1:0]    acc_wdata,
  input  logic                tick,
  output logic [REG_W-1:0]    rd_data,
  output logic                rd_valid,
  output logic                err,
  output logic [NCPU-1:0]     ipi_irq,
  output logic [NCPU-1:0]     tmr_irq
);
  acc_dec_t         dec;
  logic [REG_W-1:0] rd_word;

  mptr_decode u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .dec       (dec)
  );

  mptr_ipi_bank #(.NCPU(NCPU)) u_ipi (
    .clk    (clk),
    .rst    (rst),
    .post   (dec.post[NCPU-1:0]),
    .clr    (dec.ipi_clr[NCPU-1:0]),
    .pend_q (ipi_irq)
  );

  mptr_tmr_bank #(.NCPU(NCPU)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .ack    (dec.tmr_clr[NCPU-1:0]),
    .pend_q (tmr_irq)
  );

  always_comb begin
    rd_word = '0;
    rd_word[TMR_LSB +: NCPU]  = tmr_irq;
    rd_word[IPI_LSB +: NCPU]  = ipi_irq;
    rd_word[CPU_ID_W-1:0]     = acc_cpu;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= dec.rd_ok;
      rd_data  <= dec.rd_ok ? rd_word : '0;
      err      <= dec.bad;
    end
  end
endmodule

// File: rtl/mptr_ipi_timer_chk.sv
module mptr_ipi_timer_chk
  import mptr_pkg::*;
#(
  parameter int NCPU = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                acc_valid,
  input logic                acc_write,
  input logic [1:0]          acc_size,
  input logic [CPU_ID_W-1:0] acc_cpu,
  input logic [REG_W-1:0]    acc_wdata,
  input logic                tick,
  input logic [REG_W-1:0]    rd_data,
  input logic                rd_valid,
  input logic                err,
  input logic [NCPU-1:0]     ipi_irq,
  input logic [NCPU-1:0]     tmr_irq
);
  logic full_wr;
  assign full_wr = acc_valid && acc_write && (acc_size == 2'd3);

  for (genvar n = 0; n < NCPU; n++) begin : g_cpu
    a_r2_post_raises: assert property (@(posedge clk) disable iff (rst)
      full_wr && acc_wdata[POST_LSB+n] && !acc_wdata[IPI_LSB+n] |=> ipi_irq[n]);
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
      full_wr && acc_wdata[IPI_LSB+n] |=> !ipi_irq[n]);
    a_r4_tick_raises: assert property (@(posedge clk) disable iff (rst)
      tick |=> tmr_irq[n]);
    a_r5_ack_drops: assert property (@(posedge clk) disable iff (rst)
      full_wr && acc_wdata[TMR_LSB+n] && !tick |=> !tmr_irq[n]);
  end

  a_r6_read_fields: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_write && acc_size == 2'd3 |=>
      rd_valid && rd_data[CPU_ID_W-1:0] == $past(acc_cpu) &&
      rd_data[IPI_LSB +: NCPU] == $past(ipi_irq) && rd_data[TMR_LSB +: NCPU] == $past(tmr_irq));
  a_r9_size_err: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_size != 2'd3 |=> err && !rd_valid);
  a_r11_ipi_hold: assert property (@(posedge clk) disable iff (rst)
    !full_wr |=> $stable(ipi_irq));
  a_r11_tmr_hold: assert property (@(posedge clk) disable iff (rst)
    !full_wr && !tick |=> $stable(tmr_irq));
endmodule

bind mptr_ipi_timer mptr_ipi_timer_chk #(.NCPU(NCPU)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_size(acc_size), .acc_cpu(acc_cpu), .acc_wdata(acc_wdata), .tick(tick),
  .rd_data(rd_data), .rd_valid(rd_valid), .err(err), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
);

// File: tb/mptr_ipi_timer_tb.sv
module mptr_ipi_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_size = 2'd3;
  logic [1:0]  acc_cpu = 2'd0;
  logic [63:0] acc_wdata = '0;
  logic        tick = 1'b0;
  logic [63:0] rd_data;
  logic        rd_valid;
  logic        err;
  logic [3:0]  ipi_irq;
  logic [3:0]  tmr_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [3:0]  m_ipi = '0, m_tmr = '0;
  logic        m_err = 0, m_rdv = 0;
  logic [63:0] m_rd = '0;

  always #2 clk = ~clk;

  mptr_ipi_timer #(.NCPU(4)) u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_cpu(acc_cpu), .acc_wdata(acc_wdata), .tick(tick),
    .rd_data(rd_data), .rd_valid(rd_valid), .err(err), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "ipi_irq", 64'(ipi_irq), 64'(m_ipi));
    check(tag, "tmr_irq", 64'(tmr_irq), 64'(m_tmr));
    check(tag, "err", 64'(err), 64'(m_err));
    check(tag, "rd_valid", 64'(rd_valid), 64'(m_rdv));
    check(tag, "rd_data", rd_data, m_rd);
  endtask

  task automatic cyc(string tag, bit v, bit w, logic [1:0] sz, logic [1:0] cpu,
                     logic [63:0] d, bit tk);
    acc_valid = v; acc_write = w; acc_size = sz; acc_cpu = cpu; acc_wdata = d; tick = tk;
    @(posedge clk);
    m_rdv = 0; m_rd = '0; m_err = 0;
    if (v && sz != 2'd3) m_err = 1;
    else if (v && w) begin
      m_ipi = (m_ipi | d[15:12]) & ~d[11:8];
      m_tmr = m_tmr & ~d[7:4];
      m_err = !((|d[15:4]) || d[28]);
    end else if (v) begin
      m_rdv = 1;
      m_rd  = {52'd0, m_ipi, m_tmr, 2'd0, cpu};
    end
    if (tk) m_tmr = 4'hF;
    @(negedge clk);
    acc_valid = 0; tick = 0;
    compare(tag);
  endtask

  function automatic logic [63:0] bitv(int b);
    return 64'd1 << b;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compare("R1");
    cyc("R6", 1, 0, 2'd3, 2'd1, '0, 0);
    cyc("R2", 1, 1, 2'd3, 2'd0, bitv(13), 0);
    cyc("R2", 1, 1, 2'd3, 2'd0, bitv(13), 0);
    cyc("R2", 1, 1, 2'd3, 2'd0, bitv(12) | bitv(15), 0);
    cyc("R6", 1, 0, 2'd3, 2'd2, '0, 0);
    cyc("R3", 1, 1, 2'd3, 2'd0, bitv(9), 0);
    cyc("R3", 1, 1, 2'd3, 2'd0, bitv(9) | bitv(10), 0);
    cyc("R11", 0, 0, 2'd3, 2'd0, '0, 0);
    cyc("R4", 0, 0, 2'd3, 2'd0, '0, 1);
    cyc("R6", 1, 0, 2'd3, 2'd3, '0, 0);
    cyc("R5", 1, 1, 2'd3, 2'd0, bitv(4) | bitv(6), 0);
    cyc("R5", 1, 1, 2'd3, 2'd0, bitv(5), 1);
    cyc("R5", 1, 1, 2'd3, 2'd0, bitv(5) | bitv(7), 0);
    cyc("R7", 1, 1, 2'd3, 2'd0, bitv(28), 0);
    cyc("R8", 1, 1, 2'd3, 2'd0, bitv(0) | bitv(20) | bitv(63), 0);
    cyc("R8", 0, 0, 2'd3, 2'd0, '0, 0);
    cyc("R9", 1, 1, 2'd2, 2'd0, bitv(14) | bitv(11) | bitv(4), 0);
    cyc("R9", 1, 0, 2'd0, 2'd1, '0, 0);
    cyc("R6", 1, 0, 2'd3, 2'd1, '0, 0);
    cyc("R10", 1, 1, 2'd3, 2'd0, bitv(14) | bitv(10), 0);
    cyc("R10", 1, 1, 2'd3, 2'd0, bitv(12) | bitv(8) | bitv(13), 0);
    cyc("R6", 1, 0, 2'd3, 2'd0, '0, 0);
    cyc("R11", 0, 0, 2'd3, 2'd0, bitv(12), 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule